// File: doc/BRIEF.md
# Phase-Aligned DSD Bit Capture

This block takes six one-bit DSD streams and their bit clock and delivers them to logic running on a PCM word clock. It avoids sampling a stream close to the instant it changes. Every channel has two holding registers. The early register is loaded when the bit clock rises. The late register copies the early one when the bit clock falls, so it holds the same bit half a bit period later. Downstream logic reads only one of the two registers. It picks the one that is stable around its own word boundary.

The choice is made during a resync. A rising edge on the active-low initialisation input, or on the resync request, arms the block. The first falling bit-clock edge after that starts a phase reference that follows the bit-clock level. At the next word-clock rising edge, the level of that reference selects the register. The choice then stays fixed until the next resync. The block can also be bit-clock master. In that case it divides the system clock by a parameter (8 by default) and holds the clock high while initialisation is active. Every input passes through a synchroniser into the system-clock domain. A resync can drop or repeat one DSD bit, depending on where the word clock falls relative to the bit clock.

Top module: `dsd_phase_capture`

## Requirements
- R1: After reset, dsd_out is all zero, dsd_stb is 0, aligned is 0, buf_b_sel is 0 and dsd_bclk_out is 1.
- R2: In master mode with init_n high, dsd_bclk_out has a period of DIV system clocks (8 by default), of which DIV/2 are high.
- R3: While init_n is low, dsd_bclk_out stays 1 and aligned stays 0.
- R4: dsd_bclk_oe equals bclk_master; a value of 1 means the block drives the bit clock and 0 means the bit clock comes from dsd_bclk_in.
- R5: When buf_b_sel is 0 and aligned is 1, dsd_stb pulses once per bit period, a few system clocks after the bit clock rises. With each pulse, dsd_out carries the bits that were present at that rising edge.
- R6: When buf_b_sel is 1 and aligned is 1, dsd_stb pulses once per bit period, shortly after the bit clock falls. With each pulse, dsd_out carries the bits captured at the rising edge just before that fall.
- R7: At the first word_clk rising edge after the phase reference has started, the block sets aligned to 1. It sets buf_b_sel to 1 if the bit clock is high at that edge, and to 0 if it is low.
- R8: After a resync request, the phase reference starts only at the first falling edge of the bit clock. Word_clk edges seen before that edge do not set aligned.
- R9: While aligned stays 1, later word_clk edges leave buf_b_sel unchanged, even when they arrive in the opposite bit-clock phase.
- R10: A rising edge of init_n, or a rising edge of sync_req while init_n is high, clears aligned. No dsd_stb pulse is produced until the block aligns again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (512x sample rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_n | input | 1 | Active-low initialisation; its rising edge requests a resync |
| sync_req | input | 1 | Resync request, acting on its rising edge |
| bclk_master | input | 1 | 1: block drives the bit clock; 0: bit clock is an input |
| dsd_bclk_in | input | 1 | Bit clock input used in slave mode |
| dsd_bclk_out | output | 1 | Generated bit clock used in master mode |
| dsd_bclk_oe | output | 1 | Output enable for the bit clock pad |
| dsd_in | input | CH | DSD data, one bit per channel |
| word_clk | input | 1 | PCM word clock; its rising edge is the word boundary |
| dsd_out | output | CH | Bits from the selected holding register |
| dsd_stb | output | 1 | One-cycle pulse when the selected register takes a new bit |
| buf_b_sel | output | 1 | 1 when the half-period-late register is selected |
| aligned | output | 1 | Register selection is committed |

## Verification
Word-clock boundaries are placed in the middle of the high half of the bit clock and in the middle of the low half. This separates a correct late-register choice from a correct early-register choice, and it does so in both slave mode (a 16-cycle bit period driven by the bench) and master mode (the internal divider). Random data changes at each bit-clock fall, so a strobe taken from the wrong register or on the wrong edge shows up as a data mismatch. Two directed cases cover the timing rules. In one, a boundary arrives while the bit clock is stopped, and it must not lock. In the other, boundaries arrive in the opposite phase after lock, and the selection must not move.

// File: rtl/dsd_cap_pkg.sv
`timescale 1ns/1ps
package dsd_cap_pkg;

  typedef enum logic [1:0] {
    PH_IDLE      = 2'd0,
    PH_WAIT_FALL = 2'd1,
    PH_WAIT_WORD = 2'd2,
    PH_LOCK      = 2'd3
  } ph_state_t;

  // Level of the generated bit clock for a divider position.
  function automatic logic bclk_level(input int unsigned pos, input int unsigned half);
    return pos < half;
  endfunction

  // Clock high at the boundary means the early register moved recently,
  // so the late register is the stable one.
  function automatic logic pick_buffer(input logic phase_ref);
    return phase_ref;
  endfunction

  function automatic logic rising(input logic now, input logic prev);
    return now & ~prev;
  endfunction

endpackage

// File: rtl/dsd_sync.sv
`timescale 1ns/1ps
module dsd_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dsd_bclk_gen.sv
`timescale 1ns/1ps
module dsd_bclk_gen
  import dsd_cap_pkg::*;
#(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic bclk
);
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt, cnt_nxt;

  always_comb cnt_nxt = (cnt == CW'(DIV - 1)) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      bclk <= 1'b1;
    end else if (!run) begin
      cnt  <= '0;
      bclk <= 1'b1;
    end else begin
      cnt  <= cnt_nxt;
      bclk <= bclk_level(32'(cnt_nxt), 32'(HALF));
    end
  end

  AST_BCLK_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> bclk) else $error("bit clock not held high in init"); // R3
endmodule

// File: rtl/dsd_phase_ctrl.sv
`timescale 1ns/1ps
module dsd_phase_ctrl
  import dsd_cap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init_ok,
  input  logic resync_evt,
  input  logic rise_evt,
  input  logic fall_evt,
  input  logic word_evt,
  output logic sel_b,
  output logic aligned
);
  ph_state_t state;
  logic      phase_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PH_IDLE;
      phase_ref <= 1'b0;
      sel_b     <= 1'b0;
    end else if (!init_ok) begin
      state     <= PH_IDLE;
      phase_ref <= 1'b0;
      sel_b     <= 1'b0;
    end else if (resync_evt) begin
      state <= PH_WAIT_FALL;
    end else begin
      case (state)
        PH_WAIT_FALL: begin
          if (fall_evt) begin
            phase_ref <= 1'b0;
            state     <= PH_WAIT_WORD;
          end
        end
        PH_WAIT_WORD: begin
          if (word_evt) begin
            sel_b <= pick_buffer(phase_ref);
            state <= PH_LOCK;
          end else if (rise_evt) begin
            phase_ref <= 1'b1;
          end else if (fall_evt) begin
            phase_ref <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign aligned = (state == PH_LOCK);

  AST_LOCK_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned) |-> $past(word_evt)) else $error("lock without word edge"); // R7
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (aligned && $past(aligned)) |-> $stable(sel_b)) else $error("selection moved"); // R9
  AST_RESYNC_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    resync_evt |=> !aligned) else $error("resync kept lock"); // R10
  AST_NO_LOCK_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    !init_ok |=> !aligned) else $error("locked during init"); // R3
endmodule

// File: rtl/dsd_dual_buf.sv
`timescale 1ns/1ps
module dsd_dual_buf
  import dsd_cap_pkg::*;
#(
  parameter int CH = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] din,
  input  logic          rise_evt,
  input  logic          fall_evt,
  input  logic          sel_b,
  input  logic          pass,
  output logic [CH-1:0] dout,
  output logic          stb
);
  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic early_q, late_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        early_q <= 1'b0;
        late_q  <= 1'b0;
      end else begin
        if (rise_evt) early_q <= din[c];
        if (fall_evt) late_q  <= early_q;
      end
    end
    assign dout[c] = sel_b ? late_q : early_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb <= 1'b0;
    else        stb <= pass & (sel_b ? fall_evt : rise_evt);
  end

  AST_STB_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb) else $error("strobe on back-to-back cycles"); // R5
endmodule

// File: rtl/dsd_phase_capture.sv
`timescale 1ns/1ps
module dsd_phase_capture
  import dsd_cap_pkg::*;
#(
  parameter int CH          = 6,
  parameter int DIV         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_n,
  input  logic          sync_req,
  input  logic          bclk_master,
  input  logic          dsd_bclk_in,
  output logic          dsd_bclk_out,
  output logic          dsd_bclk_oe,
  input  logic [CH-1:0] dsd_in,
  input  logic          word_clk,
  output logic [CH-1:0] dsd_out,
  output logic          dsd_stb,
  output logic          buf_b_sel,
  output logic          aligned
);
  localparam int CTRL_W = 3;
  localparam int DATA_W = CH + 1;

  logic [CTRL_W-1:0] ctrl_s;
  logic [DATA_W-1:0] data_s;
  logic init_s, sync_s, word_s;
  logic init_p, sync_p, word_p, bclk_prev;
  logic gen_bclk, bclk_src;
  logic rise_evt, fall_evt, word_evt, resync_evt;

  dsd_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES)) u_ctrl_sync (
    .clk(clk), .rst_n(rst_n), .d({init_n, sync_req, word_clk}), .q(ctrl_s));

  // Bit clock and data share one synchroniser so they stay in step.
  dsd_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_data_sync (
    .clk(clk), .rst_n(rst_n), .d({dsd_bclk_in, dsd_in}), .q(data_s));

  assign init_s = ctrl_s[2];
  assign sync_s = ctrl_s[1];
  assign word_s = ctrl_s[0];

  dsd_bclk_gen #(.DIV(DIV)) u_gen (
    .clk(clk), .rst_n(rst_n), .run(init_s), .bclk(gen_bclk));

  assign bclk_src = bclk_master ? gen_bclk : data_s[CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_p    <= 1'b0;
      sync_p    <= 1'b0;
      word_p    <= 1'b0;
      bclk_prev <= 1'b0;
    end else begin
      init_p    <= init_s;
      sync_p    <= sync_s;
      word_p    <= word_s;
      bclk_prev <= bclk_src;
    end
  end

  assign rise_evt   = rising(bclk_src, bclk_prev);
  assign fall_evt   = rising(bclk_prev, bclk_src);
  assign word_evt   = rising(word_s, word_p);
  assign resync_evt = rising(init_s, init_p) | (rising(sync_s, sync_p) & init_s);

  dsd_phase_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .init_ok(init_s), .resync_evt(resync_evt),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .word_evt(word_evt),
    .sel_b(buf_b_sel), .aligned(aligned));

  dsd_dual_buf #(.CH(CH)) u_buf (
    .clk(clk), .rst_n(rst_n), .din(data_s[CH-1:0]), .rise_evt(rise_evt),
    .fall_evt(fall_evt), .sel_b(buf_b_sel), .pass(aligned),
    .dout(dsd_out), .stb(dsd_stb));

  assign dsd_bclk_out = gen_bclk;
  assign dsd_bclk_oe  = bclk_master;

  AST_STB_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    dsd_stb |-> $past(aligned)) else $error("strobe while unaligned"); // R10
endmodule

// File: tb/sim_dsd_phase_capture.sv
`timescale 1ns/1ps
module sim_dsd_phase_capture;
  localparam int CH = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, init_n, sync_req, bclk_master, dsd_bclk_in, word_clk;
  logic [CH-1:0] dsd_in;
  logic dsd_bclk_out, dsd_bclk_oe, dsd_stb, buf_b_sel, aligned;
  logic [CH-1:0] dsd_out;

  dsd_phase_capture #(.CH(CH)) u0 (
    .clk(clk), .rst_n(rst_n), .init_n(init_n), .sync_req(sync_req),
    .bclk_master(bclk_master), .dsd_bclk_in(dsd_bclk_in),
    .dsd_bclk_out(dsd_bclk_out), .dsd_bclk_oe(dsd_bclk_oe), .dsd_in(dsd_in),
    .word_clk(word_clk), .dsd_out(dsd_out), .dsd_stb(dsd_stb),
    .buf_b_sel(buf_b_sel), .aligned(aligned));

  int n_chk = 0, n_fail = 0, stb_cnt = 0, ph = 0;
  bit chk_en = 0, slv_run = 0, fell_flag = 0;
  logic [CH-1:0] exp_bits = '0;
  logic pin_prev = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic pin_now();
    return bclk_master ? dsd_bclk_out : dsd_bclk_in;
  endfunction

  // Stimulus driver: slave bit clock of 16 cycles, data changes on falls.
  initial forever begin
    @(negedge clk);
    if (slv_run) begin
      dsd_bclk_in = (ph < 8);
      if (ph == 8) dsd_in = CH'($urandom);
      ph = (ph + 1) % 16;
    end else begin
      dsd_bclk_in = 1'b0;
      ph = 0;
    end
    if (bclk_master && fell_flag) begin
      dsd_in = CH'($urandom);
      fell_flag = 0;
    end
  end

  // Monitor: expected bits are those present at the last bit-clock rise.
  initial forever begin
    logic pin;
    @(posedge clk); #1;
    pin = pin_now();
    if (pin && !pin_prev) exp_bits = dsd_in;
    if (!pin && pin_prev && bclk_master) fell_flag = 1;
    if (dsd_stb) begin
      stb_cnt++;
      if (chk_en) chk(dsd_out == exp_bits,
                      buf_b_sel ? "R6 late register data" : "R5 early register data",
                      dsd_out, exp_bits);
    end
    pin_prev = pin;
  end

  task automatic word_pulse(input bit want_high);
    logic p, q;
    bit hit = 0;
    p = pin_now();
    while (!hit) begin
      @(posedge clk); #1;
      q = pin_now();
      if (q == want_high && p != want_high) hit = 1;
      p = q;
    end
    if (!bclk_master) repeat (3) @(negedge clk);
    else @(negedge clk);
    word_clk = 1'b1;
    repeat (6) @(negedge clk);
    word_clk = 1'b0;
  endtask

  task automatic sync_pulse();
    @(negedge clk);
    sync_req = 1'b1;
    repeat (4) @(negedge clk);
    sync_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int bad, hi, per, s0;
    logic prev;
    void'($urandom(32'h1d5c_0a17));
    rst_n = 0; init_n = 0; sync_req = 0; bclk_master = 0;
    dsd_bclk_in = 0; word_clk = 0; dsd_in = '0;
    repeat (5) @(negedge clk);
    chk(dsd_out == '0, "R1 data at reset", dsd_out, 0);
    chk(dsd_stb == 0, "R1 strobe at reset", dsd_stb, 0);
    chk(aligned == 0 && buf_b_sel == 0, "R1 alignment at reset", {aligned, buf_b_sel}, 0);
    chk(dsd_bclk_out == 1, "R1 bit clock at reset", dsd_bclk_out, 1);
    chk(dsd_bclk_oe == 0, "R4 oe in slave mode", dsd_bclk_oe, 0);
    rst_n = 1;
    bclk_master = 1;
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (!dsd_bclk_out || aligned) bad++;
    end
    chk(bad == 0, "R3 init holds clock high and unaligned", bad, 0);
    chk(dsd_bclk_oe == 1, "R4 oe in master mode", dsd_bclk_oe, 1);

    // Master clock shape.
    init_n = 1;
    repeat (10) @(negedge clk);
    prev = pin_now();
    while (!(pin_now() && !prev)) begin prev = pin_now(); @(posedge clk); #1; end
    hi = 1; per = 0; prev = 1;
    while (1) begin
      @(posedge clk); #1;
      per++;
      if (dsd_bclk_out && !prev) break;
      if (dsd_bclk_out) hi++;
      prev = dsd_bclk_out;
    end
    chk(per == 8, "R2 master period", per, 8);
    chk(hi == 4, "R2 master high time", hi, 4);

    // Master lock with boundary in high phase.
    repeat (20) @(negedge clk);
    word_pulse(1);
    repeat (2) @(negedge clk);
    chk(aligned == 1 && buf_b_sel == 1, "R7 master high phase picks late", {aligned, buf_b_sel}, 3);
    chk_en = 1;
    repeat (200) @(negedge clk);
    chk_en = 0;

    // Slave mode, resync, boundary in low phase.
    bclk_master = 0; slv_run = 1;
    repeat (40) @(negedge clk);
    sync_pulse();
    chk(aligned == 0, "R10 resync clears alignment", aligned, 0);
    s0 = stb_cnt;
    repeat (30) @(negedge clk);
    chk(stb_cnt == s0, "R10 no strobe while unaligned", stb_cnt - s0, 0);
    word_pulse(0);
    repeat (2) @(negedge clk);
    chk(aligned == 1 && buf_b_sel == 0, "R7 slave low phase picks early", {aligned, buf_b_sel}, 2);
    repeat (10) @(negedge clk);
    chk_en = 1;
    repeat (300) @(negedge clk);
    chk_en = 0;

    // Selection held against opposite-phase boundaries.
    for (int i = 0; i < 3; i++) word_pulse(1);
    repeat (4) @(negedge clk);
    chk(aligned == 1 && buf_b_sel == 0, "R9 selection held", {aligned, buf_b_sel}, 2);

    // Boundary before any falling edge is ignored.
    slv_run = 0;
    repeat (10) @(negedge clk);
    sync_pulse();
    repeat (10) @(negedge clk);
    word_clk = 1; repeat (6) @(negedge clk); word_clk = 0;
    repeat (10) @(negedge clk);
    chk(aligned == 0, "R8 boundary before reference ignored", aligned, 0);
    slv_run = 1;
    repeat (20) @(negedge clk);
    word_pulse(1);
    repeat (2) @(negedge clk);
    chk(aligned == 1 && buf_b_sel == 1, "R7 slave high phase picks late", {aligned, buf_b_sel}, 3);
    repeat (10) @(negedge clk);
    chk_en = 1;
    repeat (300) @(negedge clk);
    chk_en = 0;

    // Random modes and phases.
    for (int r = 0; r < 8; r++) begin
      bit want, mst;
      want = 1'($urandom);
      mst  = 1'($urandom);
      bclk_master = mst;
      slv_run = !mst;
      repeat (30) @(negedge clk);
      sync_pulse();
      repeat (25) @(negedge clk);
      word_pulse(want);
      repeat (2) @(negedge clk);
      chk(aligned == 1 && buf_b_sel == want, "R7 random phase selection",
          {aligned, buf_b_sel}, {1'b1, want});
      repeat (10) @(negedge clk);
      chk_en = 1;
      repeat (150) @(negedge clk);
      chk_en = 0;
    end
    finish_run();
  end
endmodule